// File: doc/BRIEF.md
# Priority-Based Peripheral Pin Crossbar

This block places the digital signals of on-chip peripherals onto an eight-pin I/O port. Each peripheral function has an enable, and an eight-bit skip mask marks pins the crossbar must leave alone. The two UART signals have fixed pins. Every other enabled function, in a fixed priority order, takes the lowest-numbered pin that is neither skipped nor already taken. Pins that are not claimed stay general-purpose I/O.

The pin map is computed combinationally from the configuration and latched once per clock, so a configuration change never makes the pins glitch. From the latched map the block routes each chosen peripheral's output data and output enable to its pin. It also routes each pin's input back to the peripheral that owns it. A four-bit code per pin reports which function the pin carries. A sticky flag records that some enabled function found no free pin.

Top module: `pin_crossbar`

## Requirements
- R1: After reset, every pin code is 0, every `pin_oe` bit is 0, every `func_din` bit is 1 and `overflow` is 0.
- R2: Function codes are 0 GPIO, 1 UART transmit, 2 UART receive, 3 SMBus data, 4 SMBus clock, 5 comparator, 6 comparator asynchronous, 7 system clock, 8 to 10 capture/compare 0 to 2, 11 external counter input, 12 timer 0 input and 13 timer 1 input. `pin_code` bits [4p+3:4p] hold the code of pin p.
- R3: While the crossbar is enabled, an enabled UART transmit always sits on pin 4 (code 1) and an enabled UART receive always sits on pin 5 (code 2), whatever the skip mask says.
- R4: The remaining enabled functions are placed in ascending code order. Each takes the lowest-numbered pin that is not skipped and not already claimed, and pins 4 and 5 count as claimed when their UART signal is enabled. No code other than 0 appears on more than one pin.
- R5: A pin whose `skip_mask` bit is set never carries a code other than 0, except the UART codes on their fixed pins.
- R6: `smb_en` requests codes 3 and 4 together, and code 3 is placed before code 4.
- R7: `cc_count` (0 to 3) requests that many capture/compare outputs, starting with code 8.
- R8: A function that finds no free pin is not routed. `overflow` then rises on the next clock and stays at 1 until reset.
- R9: When `xbar_en` is low, every pin code reads 0, `pin_oe` is 0 and every `func_din` bit is 1 one clock later.
- R10: A pin with code 0 drives `gpio_dout`/`gpio_oe`, and a pin with code c drives `func_dout[c]`/`func_doe[c]`. `func_din[c]` is the input of the pin carrying code c, or 1 if no pin does; `func_din[0]` is always 1.
- R11: The pin map takes effect at the first rising clock edge after a configuration change and is stable between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xbar_en | input | 1 | Global crossbar enable |
| uart_tx_en | input | 1 | Request UART transmit (code 1) |
| uart_rx_en | input | 1 | Request UART receive (code 2) |
| smb_en | input | 1 | Request SMBus data and clock (codes 3, 4) |
| cmp_en | input | 1 | Request comparator output (code 5) |
| cmpa_en | input | 1 | Request comparator asynchronous output (code 6) |
| sysclk_en | input | 1 | Request system clock output (code 7) |
| cc_count | input | 2 | Number of capture/compare outputs (codes 8 to 10) |
| eci_en | input | 1 | Request external counter input (code 11) |
| t0_en | input | 1 | Request timer 0 input (code 12) |
| t1_en | input | 1 | Request timer 1 input (code 13) |
| skip_mask | input | 8 | Pins passed over by the priority placement |
| gpio_dout | input | 8 | Output data for pins left as GPIO |
| gpio_oe | input | 8 | Output enable for pins left as GPIO |
| func_dout | input | 14 | Output data per function code |
| func_doe | input | 14 | Output enable per function code |
| pin_in | input | 8 | Input level of each pin |
| pin_dout | output | 8 | Data driven to each pin |
| pin_oe | output | 8 | Output enable of each pin |
| func_din | output | 14 | Input routed to each function code |
| pin_code | output | 32 | Latched function code per pin |
| overflow | output | 1 | Sticky flag: a function could not be placed |

## Verification
The assertions assume `rst_n` is held low across at least one rising edge before the first configuration. They also assume the inputs are sampled only at rising edges, with no meaning given to changes between edges. The bench changes inputs only at falling edges and asserts reset at the start and again in the middle of the run. The skip and uniqueness properties compare the latched map with the configuration from the previous edge. They therefore depend on every configuration being held for a full cycle, and the stimulus always does this. Random configurations draw every enable and skip pattern, including those that overflow, so the sticky flag is exercised with both fitting and non-fitting requests.

// File: rtl/xb_pkg.sv
package xb_pkg;
  localparam int XB_PINS   = 8;
  localparam int XB_CODE_W = 4;
  localparam int XB_FUNCS  = 14;
  localparam int XB_CODES  = 1 << XB_CODE_W;
  localparam int TX_PIN    = 4;
  localparam int RX_PIN    = 5;
  localparam int CC_MAX    = 3;

  // function codes, in placement priority
  localparam int FN_GPIO = 0;
  localparam int FN_UTX  = 1;
  localparam int FN_URX  = 2;
  localparam int FN_SDA  = 3;
  localparam int FN_SCL  = 4;
  localparam int FN_CMP  = 5;
  localparam int FN_CMPA = 6;
  localparam int FN_SCLK = 7;
  localparam int FN_CC0  = 8;
  localparam int FN_ECI  = 11;
  localparam int FN_T0   = 12;
  localparam int FN_T1   = 13;

  typedef logic [XB_CODE_W-1:0] fcode_t;

  typedef struct packed {
    logic [XB_PINS-1:0][XB_CODE_W-1:0] codes;
    logic                               ovf;
  } alloc_t;

  // fixed UART pins first, then lowest free pin per request in code order
  function automatic alloc_t xb_allocate(input logic [XB_FUNCS-1:0] req,
                                         input logic [XB_PINS-1:0]  skip);
    alloc_t              r;
    logic [XB_PINS-1:0]  taken;
    logic                placed;
    r     = '0;
    taken = skip;
    if (req[FN_UTX]) begin
      r.codes[TX_PIN] = fcode_t'(FN_UTX);
      taken[TX_PIN]   = 1'b1;
    end
    if (req[FN_URX]) begin
      r.codes[RX_PIN] = fcode_t'(FN_URX);
      taken[RX_PIN]   = 1'b1;
    end
    for (int c = FN_SDA; c < XB_FUNCS; c++) begin
      if (req[c]) begin
        placed = 1'b0;
        for (int p = 0; p < XB_PINS; p++) begin
          if (!placed && !taken[p]) begin
            r.codes[p] = fcode_t'(c);
            taken[p]   = 1'b1;
            placed     = 1'b1;
          end
        end
        if (!placed) r.ovf = 1'b1;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/xb_alloc.sv
module xb_alloc
  import xb_pkg::*;
(
  input  logic                          uart_tx_en,
  input  logic                          uart_rx_en,
  input  logic                          smb_en,
  input  logic                          cmp_en,
  input  logic                          cmpa_en,
  input  logic                          sysclk_en,
  input  logic [1:0]                    cc_count,
  input  logic                          eci_en,
  input  logic                          t0_en,
  input  logic                          t1_en,
  input  logic [XB_PINS-1:0]            skip_mask,
  output logic [XB_PINS*XB_CODE_W-1:0]  map,
  output logic                          ovf
);
  logic [XB_FUNCS-1:0] req;
  alloc_t              res;

  always_comb begin
    req          = '0;
    req[FN_UTX]  = uart_tx_en;
    req[FN_URX]  = uart_rx_en;
    req[FN_SDA]  = smb_en;
    req[FN_SCL]  = smb_en;
    req[FN_CMP]  = cmp_en;
    req[FN_CMPA] = cmpa_en;
    req[FN_SCLK] = sysclk_en;
    req[FN_ECI]  = eci_en;
    req[FN_T0]   = t0_en;
    req[FN_T1]   = t1_en;
  end

  // capture/compare outputs: thermometer decode of the count
  logic [CC_MAX-1:0] cc_req;
  for (genvar k = 0; k < CC_MAX; k++) begin : g_cc
    assign cc_req[k] = (int'(cc_count) > k);
  end

  logic [XB_FUNCS-1:0] req_all;
  always_comb begin
    req_all = req;
    for (int k = 0; k < CC_MAX; k++) req_all[FN_CC0 + k] = cc_req[k];
  end

  assign res = xb_allocate(req_all, skip_mask);
  assign map = res.codes;
  assign ovf = res.ovf;
endmodule

// File: rtl/xb_route.sv
module xb_route
  import xb_pkg::*;
(
  input  logic                          en,
  input  logic [XB_PINS*XB_CODE_W-1:0]  codes,
  input  logic [XB_PINS-1:0]            gpio_dout,
  input  logic [XB_PINS-1:0]            gpio_oe,
  input  logic [XB_FUNCS-1:0]           func_dout,
  input  logic [XB_FUNCS-1:0]           func_doe,
  input  logic [XB_PINS-1:0]            pin_in,
  output logic [XB_PINS-1:0]            pin_dout,
  output logic [XB_PINS-1:0]            pin_oe,
  output logic [XB_FUNCS-1:0]           func_din
);
  localparam int PAD_W = XB_CODES - XB_FUNCS;

  logic [XB_CODES-1:0] dout_ext, doe_ext;
  assign dout_ext = {{PAD_W{1'b0}}, func_dout};
  assign doe_ext  = {{PAD_W{1'b0}}, func_doe};

  // per-pin output mux
  for (genvar p = 0; p < XB_PINS; p++) begin : g_pin
    fcode_t sel;
    assign sel = codes[p*XB_CODE_W +: XB_CODE_W];
    always_comb begin
      if (sel == fcode_t'(FN_GPIO)) begin
        pin_dout[p] = gpio_dout[p];
        pin_oe[p]   = en & gpio_oe[p];
      end else begin
        pin_dout[p] = dout_ext[sel];
        pin_oe[p]   = en & doe_ext[sel];
      end
    end
  end

  // per-function input gather, idle high
  assign func_din[FN_GPIO] = 1'b1;
  for (genvar c = 1; c < XB_FUNCS; c++) begin : g_fn
    always_comb begin
      func_din[c] = 1'b1;
      for (int p = 0; p < XB_PINS; p++)
        if (en && codes[p*XB_CODE_W +: XB_CODE_W] == fcode_t'(c))
          func_din[c] = pin_in[p];
    end
  end
endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
  import xb_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          xbar_en,
  input  logic                          uart_tx_en,
  input  logic                          uart_rx_en,
  input  logic                          smb_en,
  input  logic                          cmp_en,
  input  logic                          cmpa_en,
  input  logic                          sysclk_en,
  input  logic [1:0]                    cc_count,
  input  logic                          eci_en,
  input  logic                          t0_en,
  input  logic                          t1_en,
  input  logic [XB_PINS-1:0]            skip_mask,
  input  logic [XB_PINS-1:0]            gpio_dout,
  input  logic [XB_PINS-1:0]            gpio_oe,
  input  logic [XB_FUNCS-1:0]           func_dout,
  input  logic [XB_FUNCS-1:0]           func_doe,
  input  logic [XB_PINS-1:0]            pin_in,
  output logic [XB_PINS-1:0]            pin_dout,
  output logic [XB_PINS-1:0]            pin_oe,
  output logic [XB_FUNCS-1:0]           func_din,
  output logic [XB_PINS*XB_CODE_W-1:0]  pin_code,
  output logic                          overflow
);
  // named internal events, observed by the checker
  logic [XB_PINS*XB_CODE_W-1:0] map_next;
  logic                         alloc_ovf;

  logic [XB_PINS*XB_CODE_W-1:0] code_q;
  logic                         en_q;
  logic                         ovf_q;

  xb_alloc u_alloc (
    .uart_tx_en (uart_tx_en),
    .uart_rx_en (uart_rx_en),
    .smb_en     (smb_en),
    .cmp_en     (cmp_en),
    .cmpa_en    (cmpa_en),
    .sysclk_en  (sysclk_en),
    .cc_count   (cc_count),
    .eci_en     (eci_en),
    .t0_en      (t0_en),
    .t1_en      (t1_en),
    .skip_mask  (skip_mask),
    .map        (map_next),
    .ovf        (alloc_ovf)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      en_q   <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      en_q   <= xbar_en;
      code_q <= xbar_en ? map_next : '0;
      ovf_q  <= ovf_q | (xbar_en & alloc_ovf);
    end
  end

  xb_route u_route (
    .en        (en_q),
    .codes     (code_q),
    .gpio_dout (gpio_dout),
    .gpio_oe   (gpio_oe),
    .func_dout (func_dout),
    .func_doe  (func_doe),
    .pin_in    (pin_in),
    .pin_dout  (pin_dout),
    .pin_oe    (pin_oe),
    .func_din  (func_din)
  );

  assign pin_code = code_q;
  assign overflow = ovf_q;
endmodule

// File: rtl/xb_checker.sv
module xb_checker
  import xb_pkg::*;
(
  input logic                          clk,
  input logic                          rst_n,
  input logic                          xbar_en,
  input logic                          uart_tx_en,
  input logic                          uart_rx_en,
  input logic [XB_PINS-1:0]            skip_mask,
  input logic [XB_PINS*XB_CODE_W-1:0]  pin_code,
  input logic [XB_PINS-1:0]            pin_oe,
  input logic [XB_FUNCS-1:0]           func_din,
  input logic                          overflow,
  input logic                          alloc_ovf
);
  // R3: fixed UART pins
  assert_uart_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xbar_en && uart_tx_en) |=> pin_code[TX_PIN*XB_CODE_W +: XB_CODE_W] == fcode_t'(FN_UTX));
  assert_uart_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xbar_en && uart_rx_en) |=> pin_code[RX_PIN*XB_CODE_W +: XB_CODE_W] == fcode_t'(FN_URX));

  // R5: skipped pins hold only GPIO or their fixed UART code
  for (genvar p = 0; p < XB_PINS; p++) begin : g_skip
    fcode_t cd;
    assign cd = pin_code[p*XB_CODE_W +: XB_CODE_W];
    assert_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      skip_mask[p] |=> (cd == fcode_t'(FN_GPIO)) ||
                       (p == TX_PIN && cd == fcode_t'(FN_UTX)) ||
                       (p == RX_PIN && cd == fcode_t'(FN_URX)));
  end

  // R4: each non-GPIO code on at most one pin
  for (genvar c = 1; c < XB_FUNCS; c++) begin : g_uniq
    logic [XB_PINS-1:0] hit;
    for (genvar p = 0; p < XB_PINS; p++) begin : g_h
      assign hit[p] = pin_code[p*XB_CODE_W +: XB_CODE_W] == fcode_t'(c);
    end
    assert_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
  end

  // R8: overflow raised and sticky
  assert_ovf_raise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xbar_en && alloc_ovf) |=> overflow);
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9: disabled crossbar
  assert_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xbar_en |=> (pin_oe == '0) && (&func_din) && (pin_code == '0));
endmodule

bind pin_crossbar xb_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xbar_en    (xbar_en),
  .uart_tx_en (uart_tx_en),
  .uart_rx_en (uart_rx_en),
  .skip_mask  (skip_mask),
  .pin_code   (pin_code),
  .pin_oe     (pin_oe),
  .func_din   (func_din),
  .overflow   (overflow),
  .alloc_ovf  (alloc_ovf)
);

// File: tb/pin_crossbar_test.sv
module pin_crossbar_test;
  localparam int NP = 8;
  localparam int NF = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xbar_en = 0, uart_tx_en = 0, uart_rx_en = 0, smb_en = 0, cmp_en = 0;
  logic cmpa_en = 0, sysclk_en = 0, eci_en = 0, t0_en = 0, t1_en = 0;
  logic [1:0] cc_count = 0;
  logic [NP-1:0] skip_mask = 0, gpio_dout = 0, gpio_oe = 0, pin_in = 0;
  logic [NF-1:0] func_dout = 0, func_doe = 0;
  logic [NP-1:0] pin_dout, pin_oe;
  logic [NF-1:0] func_din;
  logic [NP*4-1:0] pin_code;
  logic overflow;

  int checks = 0, errors = 0;
  logic finished = 0;
  logic [NP*4-1:0] exp_map = '0;
  logic exp_ovf = 0;

  always #5 clk = ~clk;

  pin_crossbar uut (.*);

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference: k-th request (in code order) goes to k-th free pin
  function automatic logic [NP*4-1:0] ref_map(input logic [NF-1:0] rq,
                                              input logic [NP-1:0] sk,
                                              output logic ov);
    int free_pins[$];
    int wants[$];
    logic [NP*4-1:0] m = '0;
    logic [NP-1:0] blocked = sk;
    if (rq[1]) begin m[19:16] = 4'd1; blocked[4] = 1; end
    if (rq[2]) begin m[23:20] = 4'd2; blocked[5] = 1; end
    for (int p = 0; p < NP; p++) if (!blocked[p]) free_pins.push_back(p);
    for (int c = 3; c < NF; c++) if (rq[c]) wants.push_back(c);
    ov = wants.size() > free_pins.size();
    for (int k = 0; k < wants.size() && k < free_pins.size(); k++)
      m[free_pins[k]*4 +: 4] = 4'(wants[k]);
    return m;
  endfunction

  function automatic logic [NF-1:0] cur_req();
    logic [NF-1:0] r = '0;
    r[1] = uart_tx_en; r[2] = uart_rx_en; r[3] = smb_en; r[4] = smb_en;
    r[5] = cmp_en; r[6] = cmpa_en; r[7] = sysclk_en;
    r[8] = cc_count >= 1; r[9] = cc_count >= 2; r[10] = cc_count == 3;
    r[11] = eci_en; r[12] = t0_en; r[13] = t1_en;
    return r;
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    exp_map = '0; exp_ovf = 0;
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic apply(input string tag);
    logic ov;
    logic [NP*4-1:0] m;
    m = ref_map(cur_req(), skip_mask, ov);
    if (!xbar_en) begin m = '0; ov = 0; end
    @(negedge clk);
    exp_map = m;
    exp_ovf = exp_ovf | ov;
    check({tag, " R4 map"}, 64'(pin_code), 64'(exp_map));
    check({tag, " R8 overflow"}, 64'(overflow), 64'(exp_ovf));
  endtask

  task automatic check_routing(input string tag);
    logic [NP-1:0] ed, eo;
    logic [NF-1:0] ei;
    gpio_dout = 8'($urandom); gpio_oe = 8'($urandom); pin_in = 8'($urandom);
    func_dout = 14'($urandom); func_doe = 14'($urandom);
    #1;
    ei = '1;
    for (int p = 0; p < NP; p++) begin
      int c = int'(exp_map[p*4 +: 4]);
      ed[p] = (c == 0) ? gpio_dout[p] : func_dout[c];
      eo[p] = xbar_en ? ((c == 0) ? gpio_oe[p] : func_doe[c]) : 1'b0;
      if (c != 0) ei[c] = pin_in[p];
    end
    check({tag, " R10 dout"}, 64'(pin_dout), 64'(ed));
    check({tag, " R10 oe"}, 64'(pin_oe), 64'(eo));
    check({tag, " R10 din"}, 64'(func_din), 64'(ei));
  endtask

  task automatic clear_cfg();
    uart_tx_en = 0; uart_rx_en = 0; smb_en = 0; cmp_en = 0; cmpa_en = 0;
    sysclk_en = 0; cc_count = 0; eci_en = 0; t0_en = 0; t1_en = 0; skip_mask = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1357));
    do_reset();
    @(negedge clk);
    check("R1 reset codes", 64'(pin_code), 0);
    check("R1 reset oe", 64'(pin_oe), 0);
    check("R1 reset din", 64'(func_din), 64'(14'h3fff));
    check("R1 reset overflow", 64'(overflow), 0);

    // skip 0x44 with mixed requests (R2 code layout, R5 skip, R6 pair order)
    @(negedge clk);
    xbar_en = 1; skip_mask = 8'h44; smb_en = 1; cmp_en = 1; sysclk_en = 1;
    apply("skip44");
    check("R6 sda on pin0", 64'(pin_code[3:0]), 3);
    check("R5 pin2 skipped", 64'(pin_code[11:8]), 0);
    check_routing("skip44");

    // UART on skipped pins, everything else shifts around (R3)
    clear_cfg(); uart_tx_en = 1; uart_rx_en = 1; skip_mask = 8'h30; cc_count = 3;
    apply("uart fixed");
    check("R3 tx pin4", 64'(pin_code[19:16]), 1);
    check("R3 rx pin5", 64'(pin_code[23:20]), 2);
    check("R7 cc2 pin2", 64'(pin_code[11:8]), 10);
    check_routing("uart fixed");

    // R11: change config, outputs hold until the next rising edge
    clear_cfg(); t1_en = 1;
    #1 check("R11 hold before edge", 64'(pin_code), 64'(exp_map));
    apply("t1 only");
    check("R11 t1 pin0", 64'(pin_code[3:0]), 13);

    // overflow then a fitting config: sticky (R8)
    clear_cfg(); skip_mask = 8'hff; smb_en = 1;
    apply("full skip");
    clear_cfg(); cmp_en = 1;
    apply("after ovf");
    check("R8 sticky", 64'(overflow), 1);

    // disable (R9)
    xbar_en = 0; uart_tx_en = 1;
    apply("disabled");
    check_routing("disabled R9");
    do_reset();
    @(negedge clk);
    check("R1 ovf cleared", 64'(overflow), 0);

    // constrained random
    for (int i = 0; i < 400; i++) begin
      xbar_en = ($urandom % 8) != 0;
      uart_tx_en = 1'($urandom); uart_rx_en = 1'($urandom); smb_en = 1'($urandom);
      cmp_en = 1'($urandom); cmpa_en = 1'($urandom); sysclk_en = 1'($urandom);
      cc_count = 2'($urandom); eci_en = 1'($urandom); t0_en = 1'($urandom);
      t1_en = 1'($urandom);
      skip_mask = ($urandom % 3 == 0) ? 8'h00 : 8'($urandom);
      apply("random");
      check_routing("random");
      if (i == 200) do_reset();
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule